// File: doc/BRIEF.md
# IOMMU control register write path

This block is the write half of the memory-mapped register file of an I/O memory-management unit. Software sends 32-bit or 64-bit stores over a simple request/response bus; the block folds the two 64 KiB register pages onto one map, decodes the offset and updates the control, error-acknowledge, stream-table and queue registers. Each accepted request gets a one-cycle response one clock later, with an error flag for an unsupported access size.

Besides plain storage it has a few side effects. The control-0 acknowledge copy has its reserved bits forced to zero. A write to the low half of a queue base recomputes that queue's log2 size, clamped to a per-queue limit. A stream-table configuration write in the two-level format captures the split width and latches a sticky two-level flag. The global-error acknowledge register is updated by toggling. Three writes pulse a kick line that tells the command consumer to look at its queue again. All stored values are driven out as flat buses for the read side and the queue engines.

Top module: `mmu_ctl_wr`

## Requirements
- R1: Address bit 16 is ignored when decoding, so an offset and the same offset plus 0x10000 reach the same register.
- R2: Every request with `wr_valid` high gets `resp_valid` high for exactly the next cycle. `resp_err` is 1 when `wr_size` is neither 4 nor 8 and 0 otherwise. An error request changes no register.
- R3: A 4-byte write to 0x20 stores the value in control 0 and loads `cr0_ack` with the value ANDed with 0x000003DF. Offsets 0x28 and 0x2C store control 1 and control 2.
- R4: `cmd_kick` is high for exactly the response cycle of a 4-byte write to 0x20 (control 0), 0x98 (command producer) or 0x64 (error acknowledge). It is low in every other cycle.
- R5: The 64-bit registers (error IRQ config 0x68, stream-table base 0x80, command-queue base 0x90, event-queue base 0xA0, event IRQ config 0xB0) take all 64 bits from an 8-byte write at the base offset. A 4-byte write at the base offset writes bits [31:0] and one at base+4 writes bits [63:32]. `reg64_q` holds entry j at bits [64j+63:64j], with j in the listed order.
- R6: A write that covers the low half of a queue base sets that queue's log2 size to min(data[4:0], limit); the limit is 19 for both queues by default. A 4-byte write to base+4 leaves the size unchanged.
- R7: A 4-byte write to 0x88 stores the value. When bits [17:16] equal 1, bits [10:6] go to `st_split` and `st_two_level` is set. `st_two_level` stays set until reset, and other format values leave the split and the flag unchanged.
- R8: A 4-byte write to 0x64 flips an acknowledge bit only where the new value differs from the stored bit and that bit is pending (`gerr_flags` differs from the stored bit). All other bits keep their value.
- R9: Writes to unmapped or read-only offsets (such as 0x00, 0x24, 0x60), and 8-byte writes to 32-bit-only offsets, change nothing and respond with `resp_err` low.
- R10: After reset every register, the size fields, the split, the flag, `resp_valid`, `resp_err` and `cmd_kick` are zero.
- R11: The 4-byte offsets 0x50, 0x70, 0x74, 0x9C, 0xA8, 0xAC, 0xB8 and 0xBC store data[31:0]. `reg32_q` holds entry i at bits [32i+31:32i], with i = 0 to 13 for 0x20, 0x28, 0x2C, 0x50, 0x64, 0x70, 0x74, 0x88, 0x98, 0x9C, 0xA8, 0xAC, 0xB8, 0xBC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request present this cycle |
| wr_addr | input | AW (17) | Byte offset into the two register pages |
| wr_data | input | 64 | Write data, 32-bit value in [31:0] |
| wr_size | input | 4 | Access size in bytes |
| gerr_flags | input | 32 | Current global error flags |
| resp_valid | output | 1 | Response for the previous cycle's request |
| resp_err | output | 1 | Response carries an error |
| cmd_kick | output | 1 | One-cycle command consumer kick |
| reg32_q | output | 448 | Packed 32-bit registers |
| cr0_ack | output | 32 | Control-0 acknowledge copy |
| reg64_q | output | 320 | Packed 64-bit registers |
| cmdq_log2 | output | 5 | Command queue log2 size |
| evtq_log2 | output | 5 | Event queue log2 size |
| st_split | output | 5 | Captured stream-table split |
| st_two_level | output | 1 | Sticky two-level table flag |

## Verification
All register state is driven to ports, so a wrong write-enable or a wrong half-select shows up as a mismatching field in the cycle right after the offending write, and it stays visible until that register is written again. A wrong toggle mask on the acknowledge register shows only when software writes a non-pending bit, so the stimulus changes the error flags between acknowledge writes. A misdecoded kick or size error shows in the same response cycle. The size clamp is driven at, just above and well above the limit, and high-half writes come after low-half writes, so a stray size recompute changes the size output at once.

// File: rtl/mmu_ctl_wr_pkg.sv
package mmu_ctl_wr_pkg;
  localparam int N32      = 14;
  localparam int N64      = 5;
  localparam int PAGE_BIT = 16;
  localparam int SIZE_W   = 4;

  // 32-bit register slots
  localparam int IX_CTL0   = 0;
  localparam int IX_GACK   = 4;
  localparam int IX_STCFG  = 7;
  localparam int IX_CQPROD = 8;

  // 64-bit register slots
  localparam int IX_CQBASE = 2;
  localparam int IX_EQBASE = 3;

  localparam logic [31:0] CTL0_RSVD = 32'hFFFF_FC20;
  localparam logic [1:0]  FMT_TWO_LEVEL = 2'b01;

  function automatic logic [15:0] off32(input int i);
    case (i)
      0:  off32 = 16'h0020;  1:  off32 = 16'h0028;
      2:  off32 = 16'h002C;  3:  off32 = 16'h0050;
      4:  off32 = 16'h0064;  5:  off32 = 16'h0070;
      6:  off32 = 16'h0074;  7:  off32 = 16'h0088;
      8:  off32 = 16'h0098;  9:  off32 = 16'h009C;
      10: off32 = 16'h00A8;  11: off32 = 16'h00AC;
      12: off32 = 16'h00B8;  default: off32 = 16'h00BC;
    endcase
  endfunction

  function automatic logic [15:0] off64(input int j);
    case (j)
      0: off64 = 16'h0068;  1: off64 = 16'h0080;
      2: off64 = 16'h0090;  3: off64 = 16'h00A0;
      default: off64 = 16'h00B0;
    endcase
  endfunction
endpackage

// File: rtl/mmu_ctl_wr_dec.sv
module mmu_ctl_wr_dec
  import mmu_ctl_wr_pkg::*;
#(
  parameter int AW = 17
) (
  input  logic              valid,
  input  logic [AW-1:0]     addr,
  input  logic [SIZE_W-1:0] size,
  output logic [N32-1:0]    hit32,
  output logic [N64-1:0]    lo64,
  output logic [N64-1:0]    hi64,
  output logic              bad_size,
  output logic              kick
);
  logic [AW-1:0] fold;
  logic          is4, is8;

  always_comb begin
    fold           = addr;
    fold[PAGE_BIT] = 1'b0;
    is4            = (size == SIZE_W'(4));
    is8            = (size == SIZE_W'(8));
  end

  assign bad_size = valid & ~(is4 | is8);

  for (genvar i = 0; i < N32; i++) begin : g_h32
    assign hit32[i] = valid & is4 & (fold == AW'(off32(i)));
  end

  for (genvar j = 0; j < N64; j++) begin : g_h64
    logic at_base, at_hi;
    assign at_base = (fold == AW'(off64(j)));
    assign at_hi   = (fold == AW'(off64(j) + 16'd4));
    assign lo64[j] = valid & (is4 | is8) & at_base;
    assign hi64[j] = valid & ((is8 & at_base) | (is4 & at_hi));
  end

  assign kick = hit32[IX_CTL0] | hit32[IX_CQPROD] | hit32[IX_GACK];
endmodule

// File: rtl/mmu_ctl_wr_regs.sv
module mmu_ctl_wr_regs #(
  parameter int W = 32,
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   en,
  input  logic [N*W-1:0] nxt,
  output logic [N*W-1:0] q
);
  for (genvar k = 0; k < N; k++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[k*W +: W] <= '0;
      else if (en[k])  q[k*W +: W] <= nxt[k*W +: W];
    end
  end
endmodule

// File: rtl/mmu_ctl_wr_qlog.sv
module mmu_ctl_wr_qlog #(
  parameter int unsigned MAX = 19
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [4:0] field,
  output logic [4:0] q
);
  localparam logic [4:0] LIMIT = 5'(MAX);
  logic [4:0] q_d;

  always_comb q_d = (field > LIMIT) ? LIMIT : field;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= q_d;
  end
endmodule

// File: rtl/mmu_ctl_wr.sv
module mmu_ctl_wr
  import mmu_ctl_wr_pkg::*;
#(
  parameter int          AW     = 17,
  parameter int unsigned CQ_MAX = 19,
  parameter int unsigned EQ_MAX = 19
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  input  logic [AW-1:0]        wr_addr,
  input  logic [63:0]          wr_data,
  input  logic [SIZE_W-1:0]    wr_size,
  input  logic [31:0]          gerr_flags,
  output logic                 resp_valid,
  output logic                 resp_err,
  output logic                 cmd_kick,
  output logic [N32*32-1:0]    reg32_q,
  output logic [31:0]          cr0_ack,
  output logic [N64*64-1:0]    reg64_q,
  output logic [4:0]           cmdq_log2,
  output logic [4:0]           evtq_log2,
  output logic [4:0]           st_split,
  output logic                 st_two_level
);
  logic [N32-1:0]    hit32;
  logic [N64-1:0]    lo64, hi64;
  logic              bad_size, kick_d;
  logic [N32*32-1:0] nxt32;
  logic [N64*64-1:0] nxt64;
  logic [31:0]       ack_q, ack_d, hi_word;
  logic              st_en;

  mmu_ctl_wr_dec #(.AW(AW)) dec_i (
    .valid(wr_valid), .addr(wr_addr), .size(wr_size),
    .hit32(hit32), .lo64(lo64), .hi64(hi64),
    .bad_size(bad_size), .kick(kick_d)
  );

  // next values: acknowledge toggles only pending bits
  assign ack_q   = reg32_q[IX_GACK*32 +: 32];
  assign ack_d   = ack_q ^ ((ack_q ^ wr_data[31:0]) & (gerr_flags ^ ack_q));
  assign hi_word = (wr_size == SIZE_W'(8)) ? wr_data[63:32] : wr_data[31:0];

  for (genvar i = 0; i < N32; i++) begin : g_n32
    if (i == IX_GACK) begin : g_ack
      assign nxt32[i*32 +: 32] = ack_d;
    end else begin : g_pl
      assign nxt32[i*32 +: 32] = wr_data[31:0];
    end
  end

  for (genvar j = 0; j < N64; j++) begin : g_n64
    assign nxt64[j*64 +: 64] = {hi64[j] ? hi_word : reg64_q[j*64+32 +: 32],
                                lo64[j] ? wr_data[31:0] : reg64_q[j*64 +: 32]};
  end

  mmu_ctl_wr_regs #(.W(32), .N(N32)) r32_i (
    .clk(clk), .rst_n(rst_n), .en(hit32), .nxt(nxt32), .q(reg32_q)
  );

  mmu_ctl_wr_regs #(.W(64), .N(N64)) r64_i (
    .clk(clk), .rst_n(rst_n), .en(lo64 | hi64), .nxt(nxt64), .q(reg64_q)
  );

  mmu_ctl_wr_qlog #(.MAX(CQ_MAX)) cq_i (
    .clk(clk), .rst_n(rst_n), .en(lo64[IX_CQBASE]),
    .field(wr_data[4:0]), .q(cmdq_log2)
  );

  mmu_ctl_wr_qlog #(.MAX(EQ_MAX)) eq_i (
    .clk(clk), .rst_n(rst_n), .en(lo64[IX_EQBASE]),
    .field(wr_data[4:0]), .q(evtq_log2)
  );

  assign st_en = hit32[IX_STCFG] & (wr_data[17:16] == FMT_TWO_LEVEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr0_ack      <= '0;
      st_split     <= '0;
      st_two_level <= 1'b0;
    end else begin
      if (hit32[IX_CTL0]) cr0_ack <= wr_data[31:0] & ~CTL0_RSVD;
      if (st_en) begin
        st_split     <= wr_data[10:6];
        st_two_level <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      cmd_kick   <= 1'b0;
    end else begin
      resp_valid <= wr_valid;
      resp_err   <= bad_size;
      cmd_kick   <= kick_d;
    end
  end
endmodule

// File: rtl/mmu_ctl_wr_chk.sv
module mmu_ctl_wr_chk
  import mmu_ctl_wr_pkg::*;
#(
  parameter int          AW     = 17,
  parameter int unsigned CQ_MAX = 19,
  parameter int unsigned EQ_MAX = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [AW-1:0]     wr_addr,
  input logic [SIZE_W-1:0] wr_size,
  input logic [31:0]       gerr_flags,
  input logic              resp_valid,
  input logic              resp_err,
  input logic              cmd_kick,
  input logic [N32*32-1:0] reg32_q,
  input logic [31:0]       cr0_ack,
  input logic [N64*64-1:0] reg64_q,
  input logic [4:0]        cmdq_log2,
  input logic [4:0]        evtq_log2,
  input logic              st_two_level
);
  logic [AW-1:0] fold;
  logic          bad, is4;
  logic [31:0]   ack;
  always_comb begin
    fold           = wr_addr;
    fold[PAGE_BIT] = 1'b0;
    is4            = (wr_size == SIZE_W'(4));
    bad            = !(is4 || wr_size == SIZE_W'(8));
  end
  assign ack = reg32_q[IX_GACK*32 +: 32];

  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> resp_valid);
  assert_no_stray_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> !resp_valid && !resp_err && !cmd_kick);
  assert_bad_size_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && bad |=> resp_err && $stable(reg32_q) && $stable(reg64_q) && $stable(cr0_ack));
  assert_ack_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cr0_ack & CTL0_RSVD) == 32'h0);
  assert_kick_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_kick |-> resp_valid && !resp_err);
  assert_kick_on_ctl0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && is4 && fold == AW'(16'h0020) |=> cmd_kick);
  assert_qsize_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmdq_log2 <= 5'(CQ_MAX) && evtq_log2 <= 5'(EQ_MAX));
  assert_hi_keeps_size_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && is4 && fold == AW'(16'h0094) |=> $stable(cmdq_log2));
  assert_two_level_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_two_level |=> st_two_level);
  assert_ack_pending_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack ^ $past(ack)) & ~($past(gerr_flags) ^ $past(ack))) == 32'h0);
endmodule

bind mmu_ctl_wr mmu_ctl_wr_chk #(.AW(AW), .CQ_MAX(CQ_MAX), .EQ_MAX(EQ_MAX)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .wr_size(wr_size), .gerr_flags(gerr_flags), .resp_valid(resp_valid),
  .resp_err(resp_err), .cmd_kick(cmd_kick), .reg32_q(reg32_q),
  .cr0_ack(cr0_ack), .reg64_q(reg64_q), .cmdq_log2(cmdq_log2),
  .evtq_log2(evtq_log2), .st_two_level(st_two_level)
);

// File: tb/mmu_ctl_wr_tb_top.sv
module mmu_ctl_wr_tb_top;
  localparam int PERIOD = 10;
  localparam int CQM = 19;
  localparam int EQM = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wv = 1'b0;
  logic [16:0] wa = '0;
  logic [63:0] wd = '0;
  logic [3:0]  ws = '0;
  logic [31:0] gf = '0;

  logic resp_valid, resp_err, cmd_kick, st_two_level;
  logic [447:0] reg32_q;
  logic [319:0] reg64_q;
  logic [31:0]  cr0_ack;
  logic [4:0]   cmdq_log2, evtq_log2, st_split;

  always #(PERIOD/2) clk = ~clk;

  mmu_ctl_wr #(.AW(17), .CQ_MAX(CQM), .EQ_MAX(EQM)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wv), .wr_addr(wa), .wr_data(wd),
    .wr_size(ws), .gerr_flags(gf), .resp_valid(resp_valid), .resp_err(resp_err),
    .cmd_kick(cmd_kick), .reg32_q(reg32_q), .cr0_ack(cr0_ack), .reg64_q(reg64_q),
    .cmdq_log2(cmdq_log2), .evtq_log2(evtq_log2), .st_split(st_split),
    .st_two_level(st_two_level)
  );

  // reference model
  logic [31:0] m32 [14];
  logic [63:0] m64 [5];
  logic [31:0] m_ack0, d;
  logic [4:0]  m_cq, m_eq, m_split;
  logic        m_tl, m_rv, m_re, m_kick;
  logic [16:0] mo;

  function automatic logic [4:0] clampv(input logic [4:0] v, input int mx);
    return (int'(v) > mx) ? 5'(mx) : v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 14; i++) m32[i] = '0;
      for (int j = 0; j < 5; j++) m64[j] = '0;
      m_ack0 = '0; m_cq = '0; m_eq = '0; m_split = '0;
      m_tl = 0; m_rv = 0; m_re = 0; m_kick = 0;
    end else begin
      m_rv = wv; m_re = 0; m_kick = 0;
      if (wv) begin
        mo = wa & ~17'h10000;
        d  = wd[31:0];
        if (ws != 4 && ws != 8) m_re = 1;
        else if (ws == 8) begin
          case (mo)
            17'h68: m64[0] = wd;
            17'h80: m64[1] = wd;
            17'h90: begin m64[2] = wd; m_cq = clampv(wd[4:0], CQM); end
            17'hA0: begin m64[3] = wd; m_eq = clampv(wd[4:0], EQM); end
            17'hB0: m64[4] = wd;
            default: ;
          endcase
        end else begin
          case (mo)
            17'h20: begin m32[0] = d; m_ack0 = d & 32'h0000_03DF; m_kick = 1; end
            17'h28: m32[1] = d;
            17'h2C: m32[2] = d;
            17'h50: m32[3] = d;
            17'h64: begin
              for (int b = 0; b < 32; b++)
                if (d[b] != m32[4][b] && gf[b] != m32[4][b]) m32[4][b] = ~m32[4][b];
              m_kick = 1;
            end
            17'h68: m64[0][31:0] = d;
            17'h6C: m64[0][63:32] = d;
            17'h70: m32[5] = d;
            17'h74: m32[6] = d;
            17'h80: m64[1][31:0] = d;
            17'h84: m64[1][63:32] = d;
            17'h88: begin
              m32[7] = d;
              if (d[17:16] == 2'd1) begin m_split = d[10:6]; m_tl = 1; end
            end
            17'h90: begin m64[2][31:0] = d; m_cq = clampv(d[4:0], CQM); end
            17'h94: m64[2][63:32] = d;
            17'h98: begin m32[8] = d; m_kick = 1; end
            17'h9C: m32[9] = d;
            17'hA0: begin m64[3][31:0] = d; m_eq = clampv(d[4:0], EQM); end
            17'hA4: m64[3][63:32] = d;
            17'hA8: m32[10] = d;
            17'hAC: m32[11] = d;
            17'hB0: m64[4][31:0] = d;
            17'hB4: m64[4][63:32] = d;
            17'hB8: m32[12] = d;
            17'hBC: m32[13] = d;
            default: ;
          endcase
        end
      end
    end
  end

  int n_vec = 0;
  int n_bad = 0;
  string phase = "R10 reset";
  bit finished = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (phase %s) actual=%h expected=%h", tag, phase, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk("R2 resp_valid", 64'(resp_valid), 64'(m_rv));
    chk("R2 resp_err", 64'(resp_err), 64'(m_re));
    chk("R4 cmd_kick", 64'(cmd_kick), 64'(m_kick));
    chk("R3 cr0_ack", 64'(cr0_ack), 64'(m_ack0));
    for (int i = 0; i < 14; i++) begin
      if (i < 3)       chk("R3 control reg", 64'(reg32_q[i*32 +: 32]), 64'(m32[i]));
      else if (i == 4) chk("R8 error ack", 64'(reg32_q[i*32 +: 32]), 64'(m32[i]));
      else if (i == 7) chk("R7 stcfg", 64'(reg32_q[i*32 +: 32]), 64'(m32[i]));
      else             chk("R11 plain reg", 64'(reg32_q[i*32 +: 32]), 64'(m32[i]));
    end
    for (int j = 0; j < 5; j++) chk("R5 wide reg", reg64_q[j*64 +: 64], m64[j]);
    chk("R6 cmdq_log2", 64'(cmdq_log2), 64'(m_cq));
    chk("R6 evtq_log2", 64'(evtq_log2), 64'(m_eq));
    chk("R7 split", 64'(st_split), 64'(m_split));
    chk("R7 two_level", 64'(st_two_level), 64'(m_tl));
  end

  task automatic wr(input logic [16:0] a, input logic [63:0] dv, input logic [3:0] s);
    wv = 1; wa = a; wd = dv; ws = s;
    @(negedge clk);
    wv = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [16:0] pick(input int k);
    case (k)
      0: return 17'h20;  1: return 17'h28;  2: return 17'h2C;  3: return 17'h50;
      4: return 17'h64;  5: return 17'h68;  6: return 17'h6C;  7: return 17'h70;
      8: return 17'h74;  9: return 17'h80;  10: return 17'h84; 11: return 17'h88;
      12: return 17'h90; 13: return 17'h94; 14: return 17'h98; 15: return 17'h9C;
      16: return 17'hA0; 17: return 17'hA4; 18: return 17'hA8; 19: return 17'hAC;
      20: return 17'hB0; 21: return 17'hB4; 22: return 17'hB8; 23: return 17'hBC;
      24: return 17'h24; 25: return 17'h60; default: return 17'h00;
    endcase
  endfunction

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    // R3 control writes
    phase = "R3 control";
    @(negedge clk);
    wr(17'h20, 64'hFFFF_FFFF_FFFF_FFFF, 4);
    wr(17'h28, 64'h1234_5678, 4);
    wr(17'h2C, 64'h9ABC_DEF0, 4);
    wr(17'h20, 64'h0000_0C2C, 4);
    // R1 page alias
    phase = "R1 alias";
    wr(17'h10028, 64'hCAFE_0001, 4);
    wr(17'h100A8, 64'h0000_0011, 4);
    wr(17'h10080, 64'h0123_4567_89AB_CDEF, 8);
    // R2 bad sizes
    phase = "R2 size";
    wr(17'h28, 64'hDEAD, 2);
    wr(17'h20, 64'hDEAD, 1);
    wr(17'h90, 64'h1F, 0);
    wr(17'h98, 64'h3, 15);
    // R5 wide registers
    phase = "R5 wide";
    wr(17'h68, 64'h1111_2222_3333_4444, 8);
    wr(17'hB0, 64'h5555_6666_7777_8888, 8);
    wr(17'h6C, 64'hAAAA_BBBB, 4);
    wr(17'hB0, 64'hCCCC_DDDD, 4);
    wr(17'h84, 64'hEEEE_FFFF, 4);
    // R6 queue size clamp
    phase = "R6 qsize";
    wr(17'h90, 64'h1F, 4);
    wr(17'h94, 64'h3, 4);
    wr(17'h90, 64'hFFFF_0000_0000_0013, 8);
    wr(17'hA0, 64'h14, 4);
    wr(17'hA4, 64'h2, 4);
    wr(17'hA0, 64'h05, 8);
    // R7 stream table config
    phase = "R7 stcfg";
    wr(17'h88, 64'h0000_02C0, 4);
    wr(17'h88, 64'h0001_02C0, 4);
    wr(17'h88, 64'h0002_0140, 4);
    wr(17'h88, 64'h0003_07C0, 4);
    // R8 toggle acknowledge
    phase = "R8 gack";
    gf = 32'h0000_000F;
    wr(17'h64, 64'h05, 4);
    wr(17'h64, 64'hF0, 4);
    gf = 32'h0000_00F5;
    wr(17'h64, 64'hF0, 4);
    wr(17'h64, 64'h00, 4);
    // R9 ignored offsets
    phase = "R9 ignored";
    wr(17'h00, 64'hFFFF_FFFF, 4);
    wr(17'h24, 64'hFFFF_FFFF, 4);
    wr(17'h60, 64'hFFFF_FFFF, 4);
    wr(17'h28, 64'hFFFF_FFFF_FFFF_FFFF, 8);
    wr(17'h6C, 64'hFFFF_FFFF_FFFF_FFFF, 8);
    // R4 kick sources
    phase = "R4 kick";
    idle(3);
    wr(17'h98, 64'h7, 4);
    wr(17'h9C, 64'h7, 4);
    wr(17'h10098, 64'h8, 4);
    wr(17'h20, 64'h8, 8);
    // R11 plain registers
    phase = "R11 plain";
    wr(17'h50, 64'h3, 4);
    wr(17'h70, 64'h70, 4);
    wr(17'h74, 64'h74, 4);
    wr(17'hAC, 64'hAC, 4);
    wr(17'hB8, 64'hB8, 4);
    wr(17'hBC, 64'hBC, 4);
    // mixed traffic
    phase = "mixed";
    for (int n = 0; n < 600; n++) begin
      logic [16:0] a;
      logic [3:0]  s;
      int r;
      a = pick(int'($urandom_range(0, 26)));
      if ($urandom_range(0, 1) == 1) a[16] = 1'b1;
      r = int'($urandom_range(0, 9));
      s = (r < 6) ? 4'd4 : (r < 9) ? 4'd8 : 4'($urandom_range(0, 15));
      if ($urandom_range(0, 3) == 0) gf = $urandom;
      wr(a, {$urandom, $urandom}, s);
      if ($urandom_range(0, 4) == 0) idle(1);
    end
    // reset returns everything to zero
    phase = "R10 reset again";
    rst_n = 0;
    idle(2);
    rst_n = 1;
    idle(2);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog (phase %s) actual=running expected=finished", phase);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule